// File: doc/BRIEF.md
# Configuration RAM Bank Bit Walker

This block sits behind the command decoder of a configuration loader. Once a configuration-memory data command has been decoded, the block takes the following data bytes one at a time through a valid/ready handshake. It serialises each byte most significant bit first and emits one write strobe per clock. Each strobe carries the bit value and the column and row it belongs to inside the selected bank.

The write window is a rectangle inside one of four banks. It has a programmable width and height, and it starts at a programmable row, so a tall bank can be filled in several partial loads. The window parameters are captured when a start pulse arrives while the block is idle. After width × height bits the block pulses done and returns to idle. Any bits left in the last byte are thrown away.

Each bank holds one quadrant of the chip, and bank position 0 always sits at the outer corner of the chip. Alongside the bank-local position, the block gives chip-global coordinates. Bank index bit 1 mirrors the column axis and bank index bit 0 mirrors the row axis.

Top module: `cram_walker`

## Requirements
- R1: After reset, out_we, done, busy and in_ready are all 0.
- R2: A start pulse while idle captures cfg_bank, cfg_width, cfg_height and cfg_offset. Later changes on those inputs, and start pulses while busy, have no effect on the strobes of the running window.
- R3: A byte is taken on a clock edge where in_valid and in_ready are both 1. in_ready is 0 while idle. While busy it is 1 only when at most one bit of the current byte is left and that bit is not the final bit of the window.
- R4: Bits of each byte go out most significant bit first on out_bit, one bit per clock, starting the cycle after the byte is taken.
- R5: out_x starts at 0 and increases by 1 per strobe. After width-1 it wraps to 0 and out_y increases by 1. out_y starts at the captured offset.
- R6: The cycle after the strobe of bit number width × height, done is 1 for exactly one cycle, and busy and out_we are 0. The unused bits of that byte produce no strobes.
- R7: A start with width × height equal to 0 gives a one-cycle done pulse in the following cycle, no strobes, and leaves busy at 0.
- R8: out_gx equals 2·QW−1−out_x when bank bit 1 is set, and equals out_x otherwise.
- R9: out_gy equals 2·QH−1−out_y when bank bit 0 is set, and equals out_y otherwise.
- R10: When the next byte is always offered, strobes run on consecutive cycles across byte boundaries with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a window when idle |
| cfg_bank | input | 2 | Bank index |
| cfg_width | input | XW | Window width in bits |
| cfg_height | input | YW | Window height in rows |
| cfg_offset | input | YW | First row of the window |
| in_valid | input | 1 | Data byte offered |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Byte can be taken this cycle |
| busy | output | 1 | Window in progress |
| out_we | output | 1 | Bit write strobe |
| out_bit | output | 1 | Bit value |
| out_bank | output | 2 | Captured bank index |
| out_x | output | XW | Bank-local column |
| out_y | output | YW | Bank-local row |
| out_gx | output | XW | Chip-global column |
| out_gy | output | YW | Chip-global row |
| done | output | 1 | One-cycle end-of-window pulse |

## Verification
A start pulse is captured on the next edge. The first strobe of a byte appears in the cycle after the edge that takes the byte, and each further bit follows one cycle later. done rises in the cycle after the final strobe; for an empty window it rises in the cycle after the start edge.

The bench drives and samples only on falling edges, where every output is settled from registers. It logs every strobe with its cycle number, so it can check contiguity and the bit order. After each done pulse it waits a few cycles to confirm that leftover bits produce nothing.

// File: rtl/cram_walker.sv
module cram_walker #(
  parameter int QW = 332,
  parameter int QH = 144,
  localparam int XW = $clog2(2*QW+1),
  localparam int YW = $clog2(2*QH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    cfg_bank,
  input  logic [XW-1:0] cfg_width,
  input  logic [YW-1:0] cfg_height,
  input  logic [YW-1:0] cfg_offset,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          busy,
  output logic          out_we,
  output logic          out_bit,
  output logic [1:0]    out_bank,
  output logic [XW-1:0] out_x,
  output logic [YW-1:0] out_y,
  output logic [XW-1:0] out_gx,
  output logic [YW-1:0] out_gy,
  output logic          done
);
  localparam int AW = XW + YW;
  localparam logic [XW-1:0] XMAX = XW'(2*QW-1);
  localparam logic [YW-1:0] YMAX = YW'(2*QH-1);

  logic          busy_q, done_q;
  logic [1:0]    bank_q;
  logic [XW-1:0] w_q, col_q;
  logic [YW-1:0] row_q;
  logic [AW-1:0] left_q;
  logic [7:0]    sh_q;
  logic [3:0]    nb_q;

  wire [AW-1:0] area = AW'(cfg_width) * AW'(cfg_height);
  wire          take = in_valid && in_ready;

  assign busy     = busy_q;
  assign done     = done_q;
  assign out_we   = busy_q && (nb_q != 4'd0);
  assign in_ready = busy_q && (nb_q == 4'd0 || (nb_q == 4'd1 && left_q != AW'(1)));
  assign out_bit  = sh_q[7];
  assign out_bank = bank_q;
  assign out_x    = col_q;
  assign out_y    = row_q;
  assign out_gx   = bank_q[1] ? XMAX - col_q : col_q;
  assign out_gy   = bank_q[0] ? YMAX - row_q : row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      bank_q <= '0;
      w_q    <= '0;
      col_q  <= '0;
      row_q  <= '0;
      left_q <= '0;
      sh_q   <= '0;
      nb_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          bank_q <= cfg_bank;
          w_q    <= cfg_width;
          col_q  <= '0;
          row_q  <= cfg_offset;
          nb_q   <= '0;
          left_q <= area;
          busy_q <= (area != '0);
          done_q <= (area == '0);
        end
      end else begin
        if (out_we) begin
          sh_q   <= {sh_q[6:0], 1'b0};
          nb_q   <= nb_q - 4'd1;
          left_q <= left_q - AW'(1);
          if (col_q == w_q - XW'(1)) begin
            col_q <= '0;
            row_q <= row_q + YW'(1);
          end else begin
            col_q <= col_q + XW'(1);
          end
          if (left_q == AW'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            nb_q   <= '0;
          end
        end
        if (take) begin
          sh_q <= in_data;
          nb_q <= 4'd8;
        end
      end
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !out_we));
  assert_col_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (out_x < w_q));
  assert_col_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && nb_q > 4'd1 && out_x != w_q - XW'(1)) |=> (out_x == $past(out_x) + XW'(1)));
  assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_we && nb_q > 4'd1 && out_x == w_q - XW'(1)) |=> (out_x == '0 && out_y == $past(out_y) + YW'(1)));
  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(out_bank));
  assert_idle_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !out_we));
endmodule

// File: tb/tb_cram_walker.sv
module tb_cram_walker;
  localparam int CLK_PERIOD = 10;
  localparam int QW = 6;
  localparam int QH = 5;
  localparam int XW = $clog2(2*QW+1);
  localparam int YW = $clog2(2*QH+1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [1:0] cfg_bank = '0;
  logic [XW-1:0] cfg_width = '0;
  logic [YW-1:0] cfg_height = '0, cfg_offset = '0;
  logic [7:0] in_data = '0;
  logic in_ready, busy, out_we, out_bit, done;
  logic [1:0] out_bank;
  logic [XW-1:0] out_x, out_gx;
  logic [YW-1:0] out_y, out_gy;

  int checks = 0, errors = 0, cyc = 0;
  int n = 0, ndone = 0;
  int s_x[64], s_y[64], s_gx[64], s_gy[64], s_bit[64], s_bank[64], s_cyc[64];

  always #(CLK_PERIOD/2) clk = ~clk;

  cram_walker #(.QW(QW), .QH(QH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_bank(cfg_bank),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_offset(cfg_offset),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .busy(busy),
    .out_we(out_we), .out_bit(out_bit), .out_bank(out_bank), .out_x(out_x),
    .out_y(out_y), .out_gx(out_gx), .out_gy(out_gy), .done(done));

  always @(negedge clk) begin
    cyc++;
    if (rst_n && out_we && n < 64) begin
      s_x[n] = int'(out_x); s_y[n] = int'(out_y); s_gx[n] = int'(out_gx);
      s_gy[n] = int'(out_gy); s_bit[n] = int'(out_bit); s_bank[n] = int'(out_bank);
      s_cyc[n] = cyc; n++;
    end
    if (rst_n && done) ndone++;
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk("R1 out_we", int'(out_we), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 in_ready", int'(in_ready), 0);
  endtask

  task automatic run_case(input int b, input int w, input int h, input int off,
                          input logic [7:0] b0, input logic [7:0] b1, input bit poke);
    int total = w * h;
    int nbytes = (total + 7) / 8;
    logic [7:0] bytes [2];
    bytes[0] = b0; bytes[1] = b1;
    @(negedge clk);
    n = 0; ndone = 0;
    cfg_bank = 2'(b); cfg_width = XW'(w); cfg_height = YW'(h); cfg_offset = YW'(off);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_bank = ~cfg_bank; cfg_width = XW'(1); cfg_height = YW'(1); cfg_offset = YW'(0);
    chk("R3 ready_when_empty", int'(in_ready), 1);
    for (int i = 0; i < nbytes; i++) begin
      in_valid = 1'b1; in_data = bytes[i];
      if (poke && i == 1) start = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    in_valid = 1'b0;
    for (int k = 0; k < 40 && ndone == 0; k++) @(negedge clk);
    chk("R6 done_seen", ndone, 1);
    chk("R6 busy_after", int'(busy), 0);
    repeat (6) @(negedge clk);
    chk("R6 pulse_once", ndone, 1);
    chk("R6 strobe_count", n, total);
    for (int i = 0; i < n && i < total; i++) begin
      int ex = i % w;
      int ey = off + i / w;
      chk("R5 x", s_x[i], ex);
      chk("R5 y", s_y[i], ey);
      chk("R4 bit", s_bit[i], int'(bytes[i/8][7 - i%8]));
      chk("R2 bank", s_bank[i], b);
      chk("R8 gx", s_gx[i], (b & 2) ? (2*QW - 1 - ex) : ex);
      chk("R9 gy", s_gy[i], (b & 1) ? (2*QH - 1 - ey) : ey);
      if (i > 0) chk("R10 contiguous", s_cyc[i] - s_cyc[i-1], 1);
    end
  endtask

  task automatic test_zero;
    @(negedge clk);
    n = 0; ndone = 0;
    cfg_bank = 2'd2; cfg_width = XW'(4); cfg_height = YW'(0); cfg_offset = YW'(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 done_next", int'(done), 1);
    chk("R7 busy", int'(busy), 0);
    @(negedge clk);
    chk("R7 done_once", int'(done), 0);
    repeat (3) @(negedge clk);
    chk("R7 no_strobes", n, 0);
    chk("R3 idle_ready", int'(in_ready), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_case(0, 3, 2, 1, 8'hA5, 8'h00, 1'b0);
    run_case(3, 3, 3, 2, 8'hA5, 8'h3C, 1'b0);
    run_case(1, 4, 2, 0, 8'hF0, 8'h00, 1'b0);
    run_case(2, 5, 2, 3, 8'h81, 8'h7E, 1'b1);
    test_zero();
    summary();
  end
endmodule